// File: doc/BRIEF.md
# Banked Interrupt Controller with Fast-Interrupt Steering

This controller gathers edge-signalled interrupt sources into 16-bit banks and presents them to a processor on two registered request lines. One line is for normal interrupts and one is for fast interrupts. Source n belongs to bank n/16 at bit n%16. Each source has an enable bit and a steering bit. A rising edge on a source is latched into either the normal or the fast pending bank, whichever its steering bit selects. Software acknowledges a source by writing a 1 to its pending bit.

Software reaches the registers through a simple 16-bit bus with a write strobe and a combinational read. A control bit chooses between two views of the pending registers: one shows every latched bit, the other shows only the bits of enabled sources. A read-only entry-address register gives the vector table slot of the lowest-numbered enabled normal source that is pending. The slot is a programmable 32-bit base plus four bytes per source index.

Top module: `intc_banked`

## Requirements
- R1: After reset every readable register (addresses 0 to 20) reads 0. This means all sources are disabled, none is steered to the fast line, and nothing is pending. Both request lines are low.
- R2: Register map, with bank k at offset k: enable at 0+k, steering at 4+k, normal pending at 8+k, fast pending at 12+k. The raw-view control is bit 0 of address 16. The table base is at 17 (low half) and 18 (high half). The entry address is at 19 (low half) and 20 (high half). Source n uses bank n/16, bit n%16.
- R3: Writing an enable register stores the written bits: a 1 enables a source and a 0 disables it. A read returns the stored value.
- R4: A rising edge on a source whose steering bit is 1 sets its fast pending bit. With the steering bit at 0, the edge sets its normal pending bit instead.
- R5: Writing 1 to a pending bit clears it and writing 0 leaves it unchanged. Writing 0xFFFF clears the whole bank.
- R6: A rising edge in the same cycle as a clear write to that bit leaves the bit set.
- R7: With the raw-view bit at 0, pending reads show only enabled sources. With the bit at 1, they show every latched bit.
- R8: The normal line is the registered OR of the enabled normal pending bits, and the fast line is the same for the fast bits. Each line goes high on the second clock edge after a source edge.
- R9: The entry address equals base + 4 × (index of the lowest-numbered enabled, pending normal source). It equals the base alone when no such source exists. The sum carries into the high half.
- R10: Bits of bank registers beyond the last source read 0, and writes to them have no effect.
- R11: A source edge is latched while the source is disabled. Masking and acknowledging may come in either order, and a later re-enable then raises the normal line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_i | input | NUM_SRC | Interrupt sources, synchronous to clk, rising-edge sensitive |
| bus_wr_i | input | 1 | Write strobe |
| bus_addr_i | input | 5 | Register address |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data for bus_addr_i (combinational) |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The bench builds the controller with NUM_SRC = 40. This fills banks 0 and 1 and leaves bank 2 with eight live bits and eight dead ones, so the dead-bit behaviour of R10 can be observed at the bus. That setting also lets the entry-address tests use source indices above 32, where the third bank is involved. A base chosen near 0xFFFF makes the entry sum carry into the upper half.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int BANK_W = 16;
  localparam int ADDR_W = 5;

  typedef logic [BANK_W-1:0] word_t;
  typedef logic [ADDR_W-1:0] addr_t;

  // Group offsets: each group leaves room for up to four banks
  localparam addr_t A_EN  = 5'd0;
  localparam addr_t A_SEL = 5'd4;
  localparam addr_t A_IRQ = 5'd8;
  localparam addr_t A_FIQ = 5'd12;
  localparam addr_t A_RAW = 5'd16;
  localparam addr_t A_BLO = 5'd17;
  localparam addr_t A_BHI = 5'd18;
  localparam addr_t A_ELO = 5'd19;
  localparam addr_t A_EHI = 5'd20;
endpackage

// File: rtl/intc_rst_sync.sv
module intc_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n = stage_q[1];
endmodule

// File: rtl/intc_src_pend.sv
module intc_src_pend #(
  parameter int NUM_SRC = 40
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [NUM_SRC-1:0] sel_i,
  input  logic [NUM_SRC-1:0] clr_irq_i,
  input  logic [NUM_SRC-1:0] clr_fiq_i,
  output logic [NUM_SRC-1:0] pend_irq_o,
  output logic [NUM_SRC-1:0] pend_fiq_o
);
  logic [NUM_SRC-1:0] src_q, rise;
  logic [NUM_SRC-1:0] irq_q, irq_d, fiq_q, fiq_d;

  always_comb begin
    rise  = src_i & ~src_q;
    // a fresh edge outranks a same-cycle clear
    irq_d = (irq_q & ~clr_irq_i) | (rise & ~sel_i);
    fiq_d = (fiq_q & ~clr_fiq_i) | (rise &  sel_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;
      irq_q <= '0;
      fiq_q <= '0;
    end else begin
      src_q <= src_i;
      irq_q <= irq_d;
      fiq_q <= fiq_d;
    end
  end

  assign pend_irq_o = irq_q;
  assign pend_fiq_o = fiq_q;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_chk
    AST_EDGE_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (src_i[i] && !src_q[i] && !sel_i[i]) |=> pend_irq_o[i]); // R6
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_irq_i[i] && !(src_i[i] && !src_q[i])) |=> !pend_irq_o[i]); // R5
    AST_FAST_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_fiq_o[i]) |-> $past(sel_i[i])); // R4
  end
endmodule

// File: rtl/intc_first_set.sv
module intc_first_set #(
  parameter int N    = 40,
  parameter int IDXW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]    req_i,
  output logic            valid_o,
  output logic [IDXW-1:0] idx_o
);
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        valid_o = 1'b1;
        idx_o   = IDXW'(i);
      end
    end
  end
endmodule

// File: rtl/intc_banked.sv
module intc_banked
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 40
) (
  input  logic               clk,
  input  logic               arst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               bus_wr_i,
  input  logic [4:0]         bus_addr_i,
  input  logic [15:0]        bus_wdata_i,
  output logic [15:0]        bus_rdata_o,
  output logic               irq_o,
  output logic               fiq_o
);
  localparam int NBANK = (NUM_SRC + BANK_W - 1) / BANK_W;
  localparam int PADW  = NBANK * BANK_W;
  localparam int LASTW = NUM_SRC - (NBANK - 1) * BANK_W;
  localparam int IDXW  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic               rst_n;
  logic [NUM_SRC-1:0] en_q, en_d, sel_q, sel_d;
  logic [NUM_SRC-1:0] clr_irq, clr_fiq, pend_irq, pend_fiq, vis_irq, vis_fiq, req;
  logic               raw_q, raw_d, irq_q, irq_d, fiq_q, fiq_d;
  logic [31:0]        base_q, base_d, entry_q, entry_d;
  logic               enc_valid;
  logic [IDXW-1:0]    enc_idx;
  logic [PADW-1:0]    en_pad, sel_pad, irq_pad, fiq_pad;

  intc_rst_sync u_rst (.clk(clk), .arst_n(arst_n), .rst_n(rst_n));

  // per-source write decode: bank = i / 16, bit = i % 16
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    localparam int BK = i / BANK_W;
    localparam int BP = i % BANK_W;
    assign en_d[i]    = (bus_wr_i && bus_addr_i == A_EN  + 5'(BK)) ? bus_wdata_i[BP] : en_q[i];
    assign sel_d[i]   = (bus_wr_i && bus_addr_i == A_SEL + 5'(BK)) ? bus_wdata_i[BP] : sel_q[i];
    assign clr_irq[i] = bus_wr_i && (bus_addr_i == A_IRQ + 5'(BK)) && bus_wdata_i[BP];
    assign clr_fiq[i] = bus_wr_i && (bus_addr_i == A_FIQ + 5'(BK)) && bus_wdata_i[BP];
  end

  intc_src_pend #(.NUM_SRC(NUM_SRC)) u_pend (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .sel_i(sel_q),
    .clr_irq_i(clr_irq), .clr_fiq_i(clr_fiq),
    .pend_irq_o(pend_irq), .pend_fiq_o(pend_fiq)
  );

  assign req = pend_irq & en_q;

  intc_first_set #(.N(NUM_SRC), .IDXW(IDXW)) u_enc (
    .req_i(req), .valid_o(enc_valid), .idx_o(enc_idx)
  );

  // next state
  always_comb begin
    raw_d  = raw_q;
    base_d = base_q;
    if (bus_wr_i) begin
      if (bus_addr_i == A_RAW) raw_d         = bus_wdata_i[0];
      if (bus_addr_i == A_BLO) base_d[15:0]  = bus_wdata_i;
      if (bus_addr_i == A_BHI) base_d[31:16] = bus_wdata_i;
    end
    irq_d   = |req;
    fiq_d   = |(pend_fiq & en_q);
    entry_d = enc_valid ? base_q + 32'({enc_idx, 2'b00}) : base_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      sel_q   <= '0;
      raw_q   <= 1'b0;
      base_q  <= '0;
      entry_q <= '0;
      irq_q   <= 1'b0;
      fiq_q   <= 1'b0;
    end else begin
      en_q    <= en_d;
      sel_q   <= sel_d;
      raw_q   <= raw_d;
      base_q  <= base_d;
      entry_q <= entry_d;
      irq_q   <= irq_d;
      fiq_q   <= fiq_d;
    end
  end

  assign irq_o = irq_q;
  assign fiq_o = fiq_q;

  // read path
  always_comb begin
    vis_irq = raw_q ? pend_irq : (pend_irq & en_q);
    vis_fiq = raw_q ? pend_fiq : (pend_fiq & en_q);
    en_pad  = PADW'(en_q);
    sel_pad = PADW'(sel_q);
    irq_pad = PADW'(vis_irq);
    fiq_pad = PADW'(vis_fiq);
    bus_rdata_o = '0;
    for (int k = 0; k < NBANK; k++) begin
      if (bus_addr_i == A_EN  + 5'(k)) bus_rdata_o = en_pad [k*BANK_W +: BANK_W];
      if (bus_addr_i == A_SEL + 5'(k)) bus_rdata_o = sel_pad[k*BANK_W +: BANK_W];
      if (bus_addr_i == A_IRQ + 5'(k)) bus_rdata_o = irq_pad[k*BANK_W +: BANK_W];
      if (bus_addr_i == A_FIQ + 5'(k)) bus_rdata_o = fiq_pad[k*BANK_W +: BANK_W];
    end
    case (bus_addr_i)
      A_RAW:   bus_rdata_o = {15'd0, raw_q};
      A_BLO:   bus_rdata_o = base_q[15:0];
      A_BHI:   bus_rdata_o = base_q[31:16];
      A_ELO:   bus_rdata_o = entry_q[15:0];
      A_EHI:   bus_rdata_o = entry_q[31:16];
      default: ;
    endcase
  end

  AST_ENC_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    enc_valid |-> (req[enc_idx] && ((req & ((NUM_SRC'(1) << enc_idx) - NUM_SRC'(1))) == '0))); // R9
  AST_ENC_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !enc_valid |-> (req == '0)); // R9
  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(|en_q)); // R8

  if (LASTW < BANK_W) begin : g_dead
    AST_DEAD_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr_i == A_EN + 5'(NBANK - 1)) |-> (bus_rdata_o[BANK_W-1:LASTW] == '0)); // R10
  end
endmodule

// File: tb/tb_intc_banked.sv
module tb_intc_banked;
  import intc_pkg::*;

  localparam int NUM_SRC = 40;

  logic               clk = 1'b0;
  logic               arst_n;
  logic [NUM_SRC-1:0] src;
  logic               bus_wr;
  logic [4:0]         bus_addr;
  logic [15:0]        bus_wdata;
  logic [15:0]        bus_rdata;
  logic               irq_o, fiq_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  intc_banked #(.NUM_SRC(NUM_SRC)) dut (
    .clk(clk), .arst_n(arst_n), .src_i(src), .bus_wr_i(bus_wr),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .irq_o(irq_o), .fiq_o(fiq_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [4:0] a, input logic [15:0] exp, input string tag);
    bus_addr = a;
    #1;
    chk(bus_rdata == exp, tag, bus_rdata, exp);
  endtask

  task automatic pulse(input int n);
    @(negedge clk); src[n] = 1'b1;
    @(negedge clk); src[n] = 1'b0;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic clean();
    for (int k = 0; k < 3; k++) begin
      wr(A_IRQ + 5'(k), 16'hFFFF);
      wr(A_FIQ + 5'(k), 16'hFFFF);
      wr(A_EN  + 5'(k), 16'h0000);
      wr(A_SEL + 5'(k), 16'h0000);
    end
    wr(A_RAW, 16'h0000);
    wr(A_BLO, 16'h0000);
    wr(A_BHI, 16'h0000);
    step();
  endtask

  task automatic t_reset();
    for (int a = 0; a <= 20; a++) rd_chk(5'(a), 16'h0000, "R1 register after reset");
    chk(irq_o == 1'b0, "R1 irq line after reset", 32'(irq_o), 0);
    chk(fiq_o == 1'b0, "R1 fiq line after reset", 32'(fiq_o), 0);
  endtask

  task automatic t_enable();
    wr(A_EN + 5'd1, 16'hA5A5);
    rd_chk(A_EN + 5'd1, 16'hA5A5, "R3 enable holds written ones");
    wr(A_EN + 5'd1, 16'h0000);
    rd_chk(A_EN + 5'd1, 16'h0000, "R3 enable cleared by zeros");
    wr(A_EN + 5'd2, 16'h0002);
    rd_chk(A_EN + 5'd2, 16'h0002, "R2 bank 2 enable bit of source 33");
    clean();
  endtask

  task automatic t_route();
    wr(A_RAW, 16'h0001);
    wr(A_SEL, 16'h0008);
    pulse(3); pulse(5);
    rd_chk(A_FIQ, 16'h0008, "R4 steered source lands in fast pending");
    rd_chk(A_IRQ, 16'h0020, "R4 unsteered source lands in normal pending");
    clean();
  endtask

  task automatic t_w1c();
    wr(A_RAW, 16'h0001);
    pulse(1); pulse(2); pulse(3);
    rd_chk(A_IRQ, 16'h000E, "R5 three bits pending");
    wr(A_IRQ, 16'h0000);
    rd_chk(A_IRQ, 16'h000E, "R5 writing zeros leaves pending");
    wr(A_IRQ, 16'h0004);
    rd_chk(A_IRQ, 16'h000A, "R5 single bit cleared");
    wr(A_IRQ, 16'hFFFF);
    rd_chk(A_IRQ, 16'h0000, "R5 whole bank cleared");
    clean();
  endtask

  task automatic t_edge_clear();
    wr(A_RAW, 16'h0001);
    pulse(7);
    @(negedge clk);
    src[7] = 1'b1; bus_wr = 1'b1; bus_addr = A_IRQ; bus_wdata = 16'h0080;
    @(negedge clk);
    src[7] = 1'b0; bus_wr = 1'b0;
    rd_chk(A_IRQ, 16'h0080, "R6 edge in clear cycle keeps bit");
    wr(A_IRQ, 16'h0080);
    rd_chk(A_IRQ, 16'h0000, "R6 clear without edge removes bit");
    clean();
  endtask

  task automatic t_raw();
    wr(A_EN + 5'd1, 16'h0004);
    pulse(18); pulse(19);
    rd_chk(A_IRQ + 5'd1, 16'h0004, "R7 filtered view shows enabled only");
    wr(A_RAW, 16'h0001);
    rd_chk(A_IRQ + 5'd1, 16'h000C, "R7 raw view shows all latched");
    clean();
  endtask

  task automatic t_outputs();
    wr(A_EN + 5'd1, 16'h0010);
    pulse(20);
    chk(irq_o == 1'b0, "R8 irq still low one edge after source", 32'(irq_o), 0);
    step();
    chk(irq_o == 1'b1, "R8 irq high second edge (R2 source 20)", 32'(irq_o), 1);
    chk(fiq_o == 1'b0, "R8 fiq stays low", 32'(fiq_o), 0);
    wr(A_IRQ + 5'd1, 16'h0010);
    step();
    chk(irq_o == 1'b0, "R8 irq falls after clear", 32'(irq_o), 0);
    wr(A_SEL + 5'd2, 16'h0001);
    wr(A_EN  + 5'd2, 16'h0001);
    pulse(32);
    step();
    chk(fiq_o == 1'b1, "R8 fiq high for steered source 32", 32'(fiq_o), 1);
    chk(irq_o == 1'b0, "R8 irq low for steered source", 32'(irq_o), 0);
    clean();
  endtask

  task automatic t_entry();
    wr(A_BLO, 16'h1000);
    wr(A_BHI, 16'h0002);
    step();
    rd_chk(A_ELO, 16'h1000, "R9 entry low equals base when idle");
    rd_chk(A_EHI, 16'h0002, "R9 entry high equals base when idle");
    wr(A_EN, 16'h0C00);
    wr(A_EN + 5'd2, 16'h0008);
    pulse(35); step();
    rd_chk(A_ELO, 16'h108C, "R9 entry for source 35");
    pulse(11); step();
    rd_chk(A_ELO, 16'h102C, "R9 entry for source 11");
    pulse(10); step();
    rd_chk(A_ELO, 16'h1028, "R9 entry for source 10");
    pulse(2); step();
    rd_chk(A_ELO, 16'h1028, "R9 disabled source 2 ignored");
    wr(A_BLO, 16'hFFFC);
    step();
    rd_chk(A_ELO, 16'h0024, "R9 entry low after carry");
    rd_chk(A_EHI, 16'h0003, "R9 entry high after carry");
    clean();
  endtask

  task automatic t_unused();
    wr(A_EN + 5'd2, 16'hFFFF);
    rd_chk(A_EN + 5'd2, 16'h00FF, "R10 dead enable bits read zero");
    wr(A_SEL + 5'd2, 16'hFFFF);
    rd_chk(A_SEL + 5'd2, 16'h00FF, "R10 dead steering bits read zero");
    clean();
  endtask

  task automatic t_mask_ack();
    wr(A_EN, 16'h0040);
    pulse(6); step();
    chk(irq_o == 1'b1, "R11 irq raised", 32'(irq_o), 1);
    wr(A_EN, 16'h0000);
    wr(A_IRQ, 16'h0040);
    step();
    chk(irq_o == 1'b0, "R11 irq low after mask then ack", 32'(irq_o), 0);
    pulse(6);
    rd_chk(A_IRQ, 16'h0000, "R11 masked edge hidden in filtered view");
    wr(A_EN, 16'h0040);
    step();
    chk(irq_o == 1'b1, "R11 masked edge kept, raises irq on enable", 32'(irq_o), 1);
    wr(A_IRQ, 16'h0040);
    wr(A_EN, 16'h0000);
    step();
    chk(irq_o == 1'b0, "R11 irq low after ack then mask", 32'(irq_o), 0);
    pulse(6);
    wr(A_EN, 16'h0040);
    step();
    chk(irq_o == 1'b1, "R11 edge after ack-first order kept", 32'(irq_o), 1);
    clean();
  endtask

  initial begin
    arst_n = 1'b0; src = '0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    arst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_enable();
    t_route();
    t_w1c();
    t_edge_clear();
    t_raw();
    t_outputs();
    t_entry();
    t_unused();
    t_mask_ack();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got 0x0 expected 0x1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule